// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire (I2C) master. It frees a bus that a target device holds in an unknown state after a system reset or an aborted transfer. A one-cycle request on `kick_i` starts a fixed waveform on the two open-drain lines:

- a start condition;
- nine clock pulses with the data line left released, so that a target which was part-way through a byte can finish shifting it out;
- a second start condition;
- a stop condition.

The bus is then idle and ready for normal traffic, and `done_o` reports completion.

The block only asserts pull-low enables. A pad with an external pull-up turns each enable into an open-drain line, so a released line reads high. Every phase of the waveform lasts one half-period of the recovery clock. The half-period is set in system clock cycles by the parameter `HALF_DIV`. `NUM_PULSES` sets the number of dummy clocks and defaults to nine. Normal data transfer, arbitration and clock stretching are handled elsewhere.

Top module: `twb_recover`

## Requirements
- R1: During and after reset, `scl_pull_o`, `sda_pull_o`, `busy_o` and `done_o` are all 0.
- R2: When `kick_i` is sampled high while the block is idle, `busy_o` rises on the next cycle. Both lines stay released for one half-period. Then `sda_pull_o` goes to 1 while `scl_pull_o` stays 0 for one half-period (first start).
- R3: After the first start, exactly nine (`NUM_PULSES`) clock pulses follow. Each pulse is a low half (`scl_pull_o`=1) followed by a high half (`scl_pull_o`=0). `sda_pull_o` is 0 throughout every pulse.
- R4: Directly after the high half of the last pulse, `sda_pull_o` goes to 1 while SCL stays released for one half-period (second start).
- R5: After the second start, `sda_pull_o` returns to 0 with SCL released (stop). Both lines stay released for one half-period before completion.
- R6: Every phase lasts exactly `HALF_DIV` clock cycles, so `busy_o` is high for (4 + 2·`NUM_PULSES`)·`HALF_DIV` consecutive cycles per sequence.
- R7: `sda_pull_o` changes while SCL is released in both the current and the previous cycle only at the two starts (0→1) and at the stop (1→0).
- R8: `kick_i` is ignored while `busy_o` is high. A request during a sequence neither restarts nor lengthens it.
- R9: `done_o` is high for exactly one cycle, in the cycle after the stop half-period ends, with both lines released and `busy_o` low. A `kick_i` sampled high in that same cycle starts a new sequence.
- R10: Output encoding: a 1 on `scl_pull_o` or `sda_pull_o` means pull that line low. A 0 means release it, so it reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Recovery request, sampled when idle |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | High while a recovery sequence runs |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the completion pulse, and the acceptance of a new request, because the cycle in which `done_o` is high is already an idle cycle. The bench provokes this by holding `kick_i` high across several back-to-back sequences. The reference model then expects `busy_o` to be high on the cycle right after each `done_o`, with the pulse still exactly one cycle wide. A request placed in the last cycle of the stop half-period must be ignored, and the model judges this by expecting a single sequence.

// File: rtl/twb_pkg.sv
package twb_pkg;

   // Waveform phases; each non-idle phase lasts one half-period
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_PRE    = 3'd1,
      PH_START1 = 3'd2,
      PH_LOW    = 3'd3,
      PH_HIGH   = 3'd4,
      PH_START2 = 3'd5,
      PH_STOP   = 3'd6
   } phase_t;

   function automatic logic phase_pulls_scl(phase_t ph);
      return ph == PH_LOW;
   endfunction

   function automatic logic phase_pulls_sda(phase_t ph);
      return (ph == PH_START1) || (ph == PH_START2);
   endfunction

endpackage

// File: rtl/twb_halfdiv.sv
module twb_halfdiv #(
   parameter int HALF_DIV = 4,
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   initial begin
      assert (HALF_DIV >= 1) else $error("twb_halfdiv: HALF_DIV must be at least 1");
   end

   generate
      if (HALF_DIV == 1) begin : g_pass
         // every cycle closes a half-period
         assign tick_o = run_i;
      end else begin : g_cnt
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!run_i)      cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick_o = run_i && (cnt == LAST);

         // R6: two half-period ends are never adjacent when HALF_DIV > 1
         p_tick_gap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate

endmodule

// File: rtl/twb_pulsecnt.sv
module twb_pulsecnt #(
   parameter int NUM_PULSES = 9,
   localparam int PW = $clog2(NUM_PULSES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic          last_o,
   output logic [PW-1:0] count_o
);

   initial begin
      assert (NUM_PULSES >= 1) else $error("twb_pulsecnt: NUM_PULSES must be at least 1");
   end

   localparam logic [PW-1:0] FINAL = PW'(NUM_PULSES - 1);
   localparam logic [PW-1:0] LIMIT = PW'(NUM_PULSES);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr_i) cnt <= '0;
      else if (inc_i) cnt <= cnt + 1'b1;
   end

   assign last_o  = (cnt == FINAL);
   assign count_o = cnt;

   // R3: no more completed pulses than configured
   p_count_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT);

   // R3: a completion is never recorded past the limit
   p_no_extra_inc_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> cnt < LIMIT);

endmodule

// File: rtl/twb_seqfsm.sv
module twb_seqfsm
   import twb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   kick_i,
   input  logic   tick_i,
   input  logic   last_pulse_i,
   output phase_t phase_o,
   output logic   inc_o,
   output logic   clr_o,
   output logic   done_o
);

   phase_t phase, phase_nx;
   logic   done_q;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:   if (kick_i) phase_nx = PH_PRE;
         PH_PRE:    if (tick_i) phase_nx = PH_START1;
         PH_START1: if (tick_i) phase_nx = PH_LOW;
         PH_LOW:    if (tick_i) phase_nx = PH_HIGH;
         PH_HIGH:   if (tick_i) phase_nx = last_pulse_i ? PH_START2 : PH_LOW;
         PH_START2: if (tick_i) phase_nx = PH_STOP;
         PH_STOP:   if (tick_i) phase_nx = PH_IDLE;
         default:   phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         done_q <= 1'b0;
      end else begin
         phase  <= phase_nx;
         done_q <= (phase == PH_STOP) && tick_i;
      end
   end

   assign phase_o = phase;
   assign inc_o   = (phase == PH_HIGH) && tick_i;
   assign clr_o   = (phase == PH_IDLE);
   assign done_o  = done_q;

   // R8: a sequence is entered only from idle
   p_pre_from_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PRE && $past(phase) != PH_PRE) |-> $past(phase) == PH_IDLE);

   // R9: completion follows the stop phase
   p_done_after_stop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(phase) == PH_STOP && phase == PH_IDLE);

endmodule

// File: rtl/twb_recover.sv
module twb_recover
   import twb_pkg::*;
#(
   parameter int HALF_DIV   = 4,
   parameter int NUM_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic busy_o,
   output logic done_o
);

   localparam int PW = $clog2(NUM_PULSES + 1);

   phase_t        phase;
   logic          tick, inc, clr, last_pulse, done;
   logic [PW-1:0] pulses;

   twb_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (phase != PH_IDLE),
      .tick_o (tick)
   );

   twb_pulsecnt #(.NUM_PULSES(NUM_PULSES)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .inc_i   (inc),
      .last_o  (last_pulse),
      .count_o (pulses)
   );

   twb_seqfsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .kick_i       (kick_i),
      .tick_i       (tick),
      .last_pulse_i (last_pulse),
      .phase_o      (phase),
      .inc_o        (inc),
      .clr_o        (clr),
      .done_o       (done)
   );

   assign scl_pull_o = phase_pulls_scl(phase);
   assign sda_pull_o = phase_pulls_sda(phase);
   assign busy_o     = (phase != PH_IDLE);
   assign done_o     = done;

   // R7: data moves under a released clock only at start or stop edges
   p_sda_stable_high_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull_o && !$past(scl_pull_o) && sda_pull_o != $past(sda_pull_o))
      |-> (phase == PH_START1 || phase == PH_START2 || phase == PH_STOP));

   // R3: data is released whenever the clock is pulled low
   p_sda_free_in_pulse_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull_o |-> !sda_pull_o);

   // R4: second start only after all pulses have completed
   p_start2_after_pulses_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_START2) |-> pulses == PW'(NUM_PULSES));

   // R9: completion pulse is one cycle wide with both lines released
   p_done_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_released_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!scl_pull_o && !sda_pull_o && !busy_o));

endmodule

// File: tb/sim_twb_recover.sv
module sim_twb_recover;

   localparam int CLK_PERIOD = 10;
   localparam int H          = 3;
   localparam int NP         = 9;
   localparam int SEQ_LEN    = (4 + 2 * NP) * H;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kick = 1'b0;
   logic scl_pull, sda_pull, busy, done;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   twb_recover #(.HALF_DIV(H), .NUM_PULSES(NP)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .kick_i     (kick),
      .scl_pull_o (scl_pull),
      .sda_pull_o (sda_pull),
      .busy_o     (busy),
      .done_o     (done)
   );

   // ---------------- reference model: {busy, scl, sda, done} per cycle
   logic [3:0] q[$];
   logic [3:0] exp_v = 4'b0000;
   int accepted = 0;

   task automatic build_seq();
      for (int h = 0; h < 4 + 2 * NP; h++) begin
         logic s_scl, s_sda;
         if (h == 0)                 begin s_scl = 1'b0; s_sda = 1'b0; end
         else if (h == 1)            begin s_scl = 1'b0; s_sda = 1'b1; end
         else if (h < 2 + 2 * NP)    begin s_scl = ((h - 2) % 2 == 0); s_sda = 1'b0; end
         else if (h == 2 + 2 * NP)   begin s_scl = 1'b0; s_sda = 1'b1; end
         else                        begin s_scl = 1'b0; s_sda = 1'b0; end
         for (int c = 0; c < H; c++) q.push_back({1'b1, s_scl, s_sda, 1'b0});
      end
      q.push_back(4'b0001);
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         exp_v = 4'b0000;
      end else begin
         if (q.size() == 0 && kick) begin
            build_seq();
            accepted++;
         end
         if (q.size() > 0) exp_v = q.pop_front();
         else              exp_v = 4'b0000;
      end
   end

   // ---------------- checks
   task automatic check(input string req, input int act, input int expv, input string what);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
      end
   endtask

   // waveform event counters, judged at each completion pulse
   logic prev_scl = 1'b0, prev_sda = 1'b0;
   int rises = 0, starts = 0, stops = 0, sda_in_low = 0, busy_len = 0, dones = 0;
   logic kick_at_done = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         rises = 0; starts = 0; stops = 0; sda_in_low = 0; busy_len = 0;
         prev_scl = 1'b0; prev_sda = 1'b0; kick_at_done = 1'b0;
      end else begin
         // every cycle against the model; tags per field
         check("R6", busy,     exp_v[3], "busy");
         check("R3", scl_pull, exp_v[2], "scl_pull");
         check("R2", sda_pull, exp_v[1], "sda_pull");
         check("R9", done,     exp_v[0], "done");
         if (kick_at_done) check("R9", busy, 1, "busy after done with kick");
         kick_at_done = 1'b0;

         if (prev_scl && !scl_pull) rises++;
         if (!prev_scl && !scl_pull && !prev_sda && sda_pull) starts++;
         if (!prev_scl && !scl_pull && prev_sda && !sda_pull) stops++;
         if (scl_pull && sda_pull) sda_in_low++;
         if (busy) busy_len++;

         if (done) begin
            dones++;
            check("R3", rises, NP, "clock pulses in sequence");
            check("R3", sda_in_low, 0, "sda pulled during clock low");
            check("R4", starts, 2, "start conditions");
            check("R5", stops, 1, "stop conditions");
            check("R6", busy_len, SEQ_LEN, "busy length");
            check("R10", scl_pull | sda_pull, 0, "lines released at done");
            rises = 0; starts = 0; stops = 0; sda_in_low = 0; busy_len = 0;
            kick_at_done = kick;
         end
         prev_scl = scl_pull;
         prev_sda = sda_pull;
      end
   end

   // ---------------- stimulus
   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_kick();
      @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #(CLK_PERIOD * 2 + 1);
      check("R1", {scl_pull, sda_pull, busy, done}, 0, "outputs in reset");
      @(negedge clk);
      rst_n = 1'b1;
      wait_cycles(3);
      check("R1", {scl_pull, sda_pull, busy, done}, 0, "outputs after reset");

      // R2: single request, full sequence
      pulse_kick();
      wait_cycles(SEQ_LEN + 4);

      // R8: requests during a sequence are ignored
      pulse_kick();
      wait_cycles(5);
      pulse_kick();
      wait_cycles(H * 7);
      pulse_kick();
      // land a request in the last stop cycle
      wait_cycles(SEQ_LEN - H * 7 - 5 - 6);
      pulse_kick();
      wait_cycles(H + 6);
      check("R8", accepted, 2, "accepted sequences so far");
      check("R8", dones, 2, "completions so far");

      // R9: held request, back-to-back sequences
      @(negedge clk);
      kick = 1'b1;
      wait_cycles(3 * (SEQ_LEN + 1) - 2);
      kick = 1'b0;
      wait_cycles(SEQ_LEN + 4);
      check("R9", dones, accepted, "one completion per accepted request");

      // reset in the middle of a sequence
      pulse_kick();
      wait_cycles(H * 5);
      rst_n = 1'b0;
      wait_cycles(1);
      check("R1", {scl_pull, sda_pull, busy, done}, 0, "outputs under mid-run reset");
      rst_n = 1'b1;
      wait_cycles(2);
      pulse_kick();
      wait_cycles(SEQ_LEN + 4);
      check("R9", busy | done, 0, "idle after final sequence");

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule